// File: doc/BRIEF.md
# Memory Ordering Queue Pair

This block keeps memory ordering between two issue streams that share one memory port. Pending floating-point loads wait in one in-order queue, and pending stores wait in a second in-order queue. Loads leave through a memory-issue handshake, strictly oldest first. Stores leave through a commit handshake, also oldest first.

When a request is accepted, its full word address is compared with every entry already held in the other queue. Those entries are all older than the request. A load that matches an older store is marked with a hazard and is not offered to memory until that store has committed. This prevents a read-after-write violation. A store that matches an older load is marked with a hazard and is not offered for commit until that load has issued. This prevents a write-after-read violation.

A synchronous flush empties both queues in a single cycle. The block does not forward store data, does not model a cache and does not generate addresses.

Top module: `mem_order_queue`

## Requirements
- R1: After reset both queues are empty: `ld_ready_o` and `st_ready_o` are 1, and `ld_issue_valid_o` and `st_commit_valid_o` are 0.
- R2: Loads are offered to memory in the order they were accepted. A load is removed only in a cycle where `ld_issue_valid_o` and `ld_issue_ready_i` are both 1. While the load is not taken, the offered address holds steady.
- R3: Each queue holds DEPTH entries (8 by default). When a queue is full its ready output is 0, and a request presented in that state is dropped.
- R4: A load accepted while a store with an equal address is queued raises `ld_hazard_o` in its accept cycle. That load is not offered to memory until that store has committed, and `ld_stall_o` is 1 while the load waits at the head of the queue.
- R5: A store accepted while a load with an equal address is queued raises `st_hazard_o` in its accept cycle. That store is not offered for commit until that load has issued.
- R6: Only older entries take part in the comparison. A store accepted after a load never delays that load. A load accepted after a matching store has already committed is not flagged.
- R7: When a load and a store are accepted in the same cycle, the load counts as older. With equal addresses, `st_hazard_o` is 1, `ld_hazard_o` is 0, and the store waits for the load.
- R8: Stores are offered for commit in the order they were accepted. An offered store holds steady until `st_commit_ready_i` takes it.
- R9: `flush_i` empties both queues at the next clock edge. Any request presented in the flush cycle is dropped.
- R10: Addresses are compared on every bit. Addresses that differ only in bit 0 do not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous clear of both queues |
| ld_valid_i | input | 1 | Load request present |
| ld_addr_i | input | AW | Load word address |
| ld_ready_o | output | 1 | Load queue can accept |
| ld_hazard_o | output | 1 | Accepted load matches an older store |
| st_valid_i | input | 1 | Store request present |
| st_addr_i | input | AW | Store word address |
| st_ready_o | output | 1 | Store queue can accept |
| st_hazard_o | output | 1 | Accepted store matches an older load |
| ld_issue_valid_o | output | 1 | Head load may go to memory |
| ld_issue_addr_o | output | AW | Head load address |
| ld_issue_ready_i | input | 1 | Memory takes the head load |
| ld_stall_o | output | 1 | Head load waits on an older store |
| st_commit_valid_o | output | 1 | Head store may commit |
| st_commit_addr_o | output | AW | Head store address |
| st_commit_ready_i | input | 1 | Commit of the head store |

## Verification
The main function is exercised with several stimulus patterns.

- **Store first, then a load to the same address.** The load must stall until the store commits.
- **Load first, then a store to the same address.** The store must wait while the load still issues freely. Together with the first pattern, this tells the two ordering directions apart.
- **Load and store to the same address in the same cycle.** This pins down the tie rule.
- **A matching store that has already committed, and addresses that differ only in bit 0.** These show that departed entries and near-miss addresses raise no false hazard.
- **Full queues, and a flush that arrives together with a new request.** These show that dropped requests never reappear at the memory side.

// File: rtl/mdq_pkg.sv
package mdq_pkg;
  localparam int unsigned MDQ_DEPTH  = 8;
  localparam int unsigned MDQ_ADDR_W = 32;
endpackage

// File: rtl/mdq_cam.sv
module mdq_cam #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32
) (
  input  logic [AW-1:0]             addr_i,
  input  logic [DEPTH-1:0]          slot_vld_i,
  input  logic [DEPTH-1:0][AW-1:0]  slot_addr_i,
  output logic [DEPTH-1:0]          hit_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_o[g] = slot_vld_i[g] && (slot_addr_i[g] == addr_i);
  end
endmodule

// File: rtl/mdq_fifo.sv
module mdq_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic                      push_i,
  input  logic [AW-1:0]             push_addr_i,
  input  logic [DW-1:0]             push_dep_i,
  input  logic                      pop_i,
  input  logic [DW-1:0]             dep_clr_i,
  output logic                      full_o,
  output logic                      empty_o,
  output logic [IW-1:0]             wr_idx_o,
  output logic [IW-1:0]             rd_idx_o,
  output logic [AW-1:0]             head_addr_o,
  output logic [DW-1:0]             head_dep_o,
  output logic [DEPTH-1:0]          slot_vld_o,
  output logic [DEPTH-1:0][AW-1:0]  slot_addr_o
);
  logic [IW-1:0]            wr_ptr, rd_ptr;
  logic [CW-1:0]            count;
  logic [DEPTH-1:0][DW-1:0] dep_q;

  assign full_o      = (count == CW'(DEPTH));
  assign empty_o     = (count == '0);
  assign wr_idx_o    = wr_ptr;
  assign rd_idx_o    = rd_ptr;
  assign head_addr_o = slot_addr_o[rd_ptr];
  assign head_dep_o  = dep_q[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == IW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= (rd_ptr == IW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push_i && !pop_i)      count <= count + 1'b1;
      else if (!push_i && pop_i) count <= count - 1'b1;
    end
  end

  // per-slot storage; dependency bits only ever clear after capture
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_vld_o[g]  <= 1'b0;
        slot_addr_o[g] <= '0;
        dep_q[g]       <= '0;
      end else if (flush_i) begin
        slot_vld_o[g] <= 1'b0;
        dep_q[g]      <= '0;
      end else if (push_i && (wr_ptr == IW'(g))) begin
        slot_vld_o[g]  <= 1'b1;
        slot_addr_o[g] <= push_addr_i;
        dep_q[g]       <= push_dep_i;
      end else begin
        dep_q[g] <= dep_q[g] & ~dep_clr_i;
        if (pop_i && (rd_ptr == IW'(g))) slot_vld_o[g] <= 1'b0;
      end
    end
  end

  assert_push_not_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_pop_not_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_count_matches_slots_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(slot_vld_o) == int'(count));
endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
  import mdq_pkg::*;
#(
  parameter int unsigned DEPTH = MDQ_DEPTH,
  parameter int unsigned AW    = MDQ_ADDR_W,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  output logic          ld_ready_o,
  output logic          ld_hazard_o,
  input  logic          st_valid_i,
  input  logic [AW-1:0] st_addr_i,
  output logic          st_ready_o,
  output logic          st_hazard_o,
  output logic          ld_issue_valid_o,
  output logic [AW-1:0] ld_issue_addr_o,
  input  logic          ld_issue_ready_i,
  output logic          ld_stall_o,
  output logic          st_commit_valid_o,
  output logic [AW-1:0] st_commit_addr_o,
  input  logic          st_commit_ready_i
);
  logic ld_full, ld_empty, st_full, st_empty;
  logic ld_push, st_push, ld_pop, st_pop;
  logic [IW-1:0] ld_wr_idx, ld_rd_idx, st_wr_idx, st_rd_idx;
  logic [DEPTH-1:0] ld_head_dep, st_head_dep;
  logic [DEPTH-1:0] ld_slot_vld, st_slot_vld;
  logic [DEPTH-1:0][AW-1:0] ld_slot_addr, st_slot_addr;
  logic [DEPTH-1:0] ld_vs_st_hit, st_vs_ld_hit;
  logic [DEPTH-1:0] ld_pop_oh, st_pop_oh, tie_oh;
  logic [DEPTH-1:0] ld_dep_new, st_dep_new;

  assign ld_ready_o = !ld_full;
  assign st_ready_o = !st_full;
  assign ld_push    = ld_valid_i && !ld_full && !flush_i;
  assign st_push    = st_valid_i && !st_full && !flush_i;

  assign ld_issue_valid_o  = !ld_empty && (ld_head_dep == '0);
  assign ld_stall_o        = !ld_empty && (ld_head_dep != '0);
  assign st_commit_valid_o = !st_empty && (st_head_dep == '0);
  assign ld_pop = ld_issue_valid_o && ld_issue_ready_i && !flush_i;
  assign st_pop = st_commit_valid_o && st_commit_ready_i && !flush_i;

  assign ld_pop_oh = ld_pop ? (DEPTH'(1) << ld_rd_idx) : '0;
  assign st_pop_oh = st_pop ? (DEPTH'(1) << st_rd_idx) : '0;
  // same-cycle tie: load is older, so the store depends on the incoming load
  assign tie_oh = (ld_push && st_push && (ld_addr_i == st_addr_i)) ?
                  (DEPTH'(1) << ld_wr_idx) : '0;

  // departing entries are already resolved and are excluded
  assign ld_dep_new  = ld_vs_st_hit & ~st_pop_oh;
  assign st_dep_new  = (st_vs_ld_hit & ~ld_pop_oh) | tie_oh;
  assign ld_hazard_o = ld_push && (ld_dep_new != '0);
  assign st_hazard_o = st_push && (st_dep_new != '0);

  mdq_cam #(.DEPTH(DEPTH), .AW(AW)) u_ld_cam (
    .addr_i(ld_addr_i), .slot_vld_i(st_slot_vld), .slot_addr_i(st_slot_addr),
    .hit_o(ld_vs_st_hit)
  );

  mdq_cam #(.DEPTH(DEPTH), .AW(AW)) u_st_cam (
    .addr_i(st_addr_i), .slot_vld_i(ld_slot_vld), .slot_addr_i(ld_slot_addr),
    .hit_o(st_vs_ld_hit)
  );

  mdq_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DEPTH)) u_ld_q (
    .clk_i, .rst_ni, .flush_i,
    .push_i(ld_push), .push_addr_i(ld_addr_i), .push_dep_i(ld_dep_new),
    .pop_i(ld_pop), .dep_clr_i(st_pop_oh),
    .full_o(ld_full), .empty_o(ld_empty),
    .wr_idx_o(ld_wr_idx), .rd_idx_o(ld_rd_idx),
    .head_addr_o(ld_issue_addr_o), .head_dep_o(ld_head_dep),
    .slot_vld_o(ld_slot_vld), .slot_addr_o(ld_slot_addr)
  );

  mdq_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DEPTH)) u_st_q (
    .clk_i, .rst_ni, .flush_i,
    .push_i(st_push), .push_addr_i(st_addr_i), .push_dep_i(st_dep_new),
    .pop_i(st_pop), .dep_clr_i(ld_pop_oh),
    .full_o(st_full), .empty_o(st_empty),
    .wr_idx_o(st_wr_idx), .rd_idx_o(st_rd_idx),
    .head_addr_o(st_commit_addr_o), .head_dep_o(st_head_dep),
    .slot_vld_o(st_slot_vld), .slot_addr_o(st_slot_addr)
  );

  assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!ld_issue_valid_o && !st_commit_valid_o && ld_ready_o && st_ready_o));
  assert_ld_head_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_issue_valid_o && !ld_issue_ready_i && !flush_i) |=>
      (ld_issue_valid_o && $stable(ld_issue_addr_o)));
  assert_st_head_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_commit_valid_o && !st_commit_ready_i && !flush_i) |=>
      (st_commit_valid_o && $stable(st_commit_addr_o)));
  assert_ld_hazard_needs_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_hazard_o |-> !st_empty);
  assert_st_hazard_needs_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_hazard_o |-> (!ld_empty || ld_push));
  assert_tie_store_waits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_push && st_push && (ld_addr_i == st_addr_i)) |-> (st_hazard_o && !ld_hazard_o));
endmodule

// File: tb/sim_mem_order_queue.sv
module sim_mem_order_queue;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic ld_valid = 1'b0, st_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0, st_addr = '0;
  logic ld_rdy_in = 1'b0, st_rdy_in = 1'b0;
  logic ld_ready, ld_hazard, st_ready, st_hazard;
  logic ld_issue_valid, st_commit_valid, ld_stall;
  logic [AW-1:0] ld_issue_addr, st_commit_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [AW-1:0] exp_ld[$];
  logic [AW-1:0] exp_st[$];
  bit acc_ld, acc_st, haz_ld, haz_st;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_order_queue #(.DEPTH(DEPTH), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_ready_o(ld_ready), .ld_hazard_o(ld_hazard),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_ready_o(st_ready), .st_hazard_o(st_hazard),
    .ld_issue_valid_o(ld_issue_valid), .ld_issue_addr_o(ld_issue_addr),
    .ld_issue_ready_i(ld_rdy_in), .ld_stall_o(ld_stall),
    .st_commit_valid_o(st_commit_valid), .st_commit_addr_o(st_commit_addr),
    .st_commit_ready_i(st_rdy_in)
  );

  task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares every memory-side handshake with the scoreboard
  always @(negedge clk) begin
    if (rst_n && !flush) begin
      if (ld_issue_valid && ld_rdy_in) begin
        if (exp_ld.size() == 0) check_eq("R2", "unexpected load issue", ld_issue_addr, 64'hffff_ffff_ffff);
        else check_eq("R2", "load issue order", ld_issue_addr, exp_ld.pop_front());
      end
      if (st_commit_valid && st_rdy_in) begin
        if (exp_st.size() == 0) check_eq("R8", "unexpected store commit", st_commit_addr, 64'hffff_ffff_ffff);
        else check_eq("R8", "store commit order", st_commit_addr, exp_st.pop_front());
      end
    end
  end

  task automatic drive(bit lv, logic [AW-1:0] la, bit sv, logic [AW-1:0] sa);
    @(posedge clk); #1;
    ld_valid = lv; ld_addr = la; st_valid = sv; st_addr = sa;
    @(negedge clk);
    acc_ld = lv && ld_ready;
    acc_st = sv && st_ready;
    haz_ld = ld_hazard;
    haz_st = st_hazard;
    if (acc_ld) exp_ld.push_back(la);
    if (acc_st) exp_st.push_back(sa);
    @(posedge clk); #1;
    ld_valid = 1'b0; st_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=0", 1);
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "ld_ready after reset", ld_ready, 1);
    check_eq("R1", "st_ready after reset", st_ready, 1);
    check_eq("R1", "ld_issue_valid after reset", ld_issue_valid, 0);
    check_eq("R1", "st_commit_valid after reset", st_commit_valid, 0);

    // R2: plain load order
    ld_rdy_in = 0; st_rdy_in = 0;
    for (int i = 0; i < 4; i++) drive(1, 32'h1000 + i*4, 0, 0);
    ld_rdy_in = 1;
    idle(8);
    check_eq("R2", "loads drained", exp_ld.size(), 0);

    // R4: load behind matching store
    ld_rdy_in = 1; st_rdy_in = 0;
    drive(0, 0, 1, 32'h2000);
    drive(1, 32'h2000, 0, 0);
    check_eq("R4", "ld_hazard on matching load", haz_ld, 1);
    idle(3);
    @(negedge clk);
    check_eq("R4", "load held while store pending", ld_issue_valid, 0);
    check_eq("R4", "ld_stall while store pending", ld_stall, 1);
    idle(1);
    st_rdy_in = 1;
    idle(6);
    check_eq("R4", "load issued after store", exp_ld.size(), 0);
    check_eq("R4", "store committed", exp_st.size(), 0);

    // R5: store behind matching load
    ld_rdy_in = 0; st_rdy_in = 1;
    drive(1, 32'h3000, 0, 0);
    drive(0, 0, 1, 32'h3000);
    check_eq("R5", "st_hazard on matching store", haz_st, 1);
    idle(3);
    @(negedge clk);
    check_eq("R5", "store held while load pending", st_commit_valid, 0);
    idle(1);
    ld_rdy_in = 1;
    idle(6);
    check_eq("R5", "store committed after load", exp_st.size(), 0);

    // R6: committed store leaves no hazard; younger store never blocks load
    ld_rdy_in = 0; st_rdy_in = 1;
    drive(0, 0, 1, 32'h4000);
    idle(3);
    drive(1, 32'h4000, 0, 0);
    check_eq("R6", "no hazard after store committed", haz_ld, 0);
    drive(1, 32'h4100, 0, 0);
    st_rdy_in = 0;
    drive(0, 0, 1, 32'h4100);
    ld_rdy_in = 1;
    idle(5);
    check_eq("R6", "load not delayed by younger store", exp_ld.size(), 0);
    st_rdy_in = 1;
    idle(5);
    check_eq("R6", "younger store drained", exp_st.size(), 0);

    // R7: same-cycle tie
    ld_rdy_in = 0; st_rdy_in = 0;
    drive(1, 32'h5000, 1, 32'h5000);
    check_eq("R7", "store hazard on tie", haz_st, 1);
    check_eq("R7", "no load hazard on tie", haz_ld, 0);
    st_rdy_in = 1;
    idle(3);
    @(negedge clk);
    check_eq("R7", "tied store waits for load", st_commit_valid, 0);
    idle(1);
    ld_rdy_in = 1;
    idle(6);
    check_eq("R7", "tie drained", exp_ld.size() + exp_st.size(), 0);

    // R10: near-miss address
    ld_rdy_in = 1; st_rdy_in = 0;
    drive(0, 0, 1, 32'h6000);
    drive(1, 32'h6001, 0, 0);
    check_eq("R10", "no hazard on bit0 difference", haz_ld, 0);
    idle(3);
    check_eq("R10", "near-miss load issued", exp_ld.size(), 0);
    st_rdy_in = 1;
    idle(4);

    // R3 and R8: fill both queues
    ld_rdy_in = 0; st_rdy_in = 0;
    for (int i = 0; i < DEPTH; i++) drive(1, 32'h7000 + i*4, 1, 32'h8000 + i*4);
    @(negedge clk);
    check_eq("R3", "ld_ready low when full", ld_ready, 0);
    check_eq("R3", "st_ready low when full", st_ready, 0);
    drive(1, 32'h7999, 1, 32'h8999);
    check_eq("R3", "extra load refused", acc_ld, 0);
    check_eq("R3", "extra store refused", acc_st, 0);
    ld_rdy_in = 1; st_rdy_in = 1;
    idle(14);
    check_eq("R3", "exactly DEPTH loads issued", exp_ld.size(), 0);
    check_eq("R8", "exactly DEPTH stores committed", exp_st.size(), 0);
    @(negedge clk);
    check_eq("R3", "no dropped load appears", ld_issue_valid, 0);

    // R9: flush with a request in the same cycle
    ld_rdy_in = 0; st_rdy_in = 0;
    drive(1, 32'h9000, 1, 32'h9100);
    drive(1, 32'h9004, 1, 32'h9104);
    @(posedge clk); #1;
    flush = 1; ld_valid = 1; ld_addr = 32'h9777; st_valid = 1; st_addr = 32'h9888;
    @(posedge clk); #1;
    flush = 0; ld_valid = 0; st_valid = 0;
    exp_ld.delete();
    exp_st.delete();
    @(negedge clk);
    check_eq("R9", "ld_ready after flush", ld_ready, 1);
    check_eq("R9", "st_ready after flush", st_ready, 1);
    check_eq("R9", "no load after flush", ld_issue_valid, 0);
    check_eq("R9", "no store after flush", st_commit_valid, 0);
    ld_rdy_in = 1; st_rdy_in = 1;
    idle(5);
    @(negedge clk);
    check_eq("R9", "request in flush cycle dropped", ld_issue_valid | st_commit_valid, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule